// File: doc/BRIEF.md
# Bridge-Steered PWM Generator

This block builds one pulse-width-modulated waveform from a 10-bit time base and routes it to four outputs, A to D. Four output arrangements are available: one output alone, a complementary pair with a dead band between the two outputs, and two full-bridge arrangements in which one diagonal pair of the bridge is driven. Each output pair can be set to active-high or active-low.

The time base has an 8-bit timer in its upper bits and a 2-bit sub-step counter in its lower bits, so one timer step is four clocks. Period, duty, arrangement and polarity are written into staging inputs. The block copies them to its working registers only at a period boundary, so a change never cuts a pulse short. The dead-band count is copied at whichever boundary comes next: the end of the active portion or the end of the period. When the block is enabled, the first clock edge is treated as a period boundary, so the waveform starts one clock after enable.

Top module: `bridge_pwm`

## Requirements
- R1: While `en_i` is low, every output rests at its inactive level one clock later. The inactive level is 0, or 1 for an output whose polarity bit is set. The polarity inputs reach the outputs directly in this state.
- R2: After `en_i` rises, a period starts at the next clock edge. A period lasts 4*(period+1) clocks, and the sample index m runs from 0 to that length minus 1.
- R3: The internal PWM level is active for exactly `duty` clocks at the start of each period (m < duty). A duty of 0 gives no active clock.
- R4: A duty greater than or equal to 4*(period+1) keeps the PWM level active for the whole period.
- R5: Mode 2'b00 (single) puts the PWM level on A (`out_o[0]`). B, C and D (`out_o[1]`, `out_o[2]`, `out_o[3]`) stay inactive.
- R6: Mode 2'b01 (half-bridge) makes A active for m in [db, duty). B is active from duty+db to the end of the period. C and D stay inactive. A and B are never active together.
- R7: Mode 2'b10 (full-bridge forward) holds A active, puts the PWM level on D, and holds B and C inactive.
- R8: Mode 2'b11 (full-bridge reverse) holds C active, puts the PWM level on B, and holds A and D inactive.
- R9: `pol_i[0]` set makes A and C active-low. `pol_i[1]` set makes B and D active-low.
- R10: While the block runs, changes to duty, period, mode and polarity take effect only at the next period boundary.
- R11: While the block runs, a new dead-band count is taken at the end of the active portion or at the period boundary, whichever comes first. The falling-edge dead band that follows already uses the new count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Runs the generator when high |
| period_i | input | 8 | Staged period, in timer steps minus one |
| duty_i | input | 10 | Staged duty, in clocks |
| mode_i | input | 2 | Staged output arrangement |
| pol_i | input | 2 | Staged polarity: bit 0 for A/C, bit 1 for B/D |
| db_i | input | 6 | Staged dead-band count, in clocks |
| out_o | output | 4 | Outputs A..D on bits 0..3 |

## Verification
The bench changes duty, mode and polarity partway through a period and checks that the current period still completes with the old values. A design without buffering would shorten or extend that pulse, or switch the pins before the boundary. The bench changes the dead-band count during the active portion and expects the very next falling-edge dead band to use the new count. A design that loads the count only at the period boundary would release B too early. The bench also covers duty at zero, duty equal to and above the period length, and dead band in half-bridge mode. These cases expose off-by-one compares, a missing saturation that lets the timer wrap, and overlap between A and B.

// File: rtl/bridge_pwm.sv
module bridge_pwm #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  parameter int DB_W  = 6,
  localparam int TB_W = TMR_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [TB_W-1:0]  duty_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       pol_i,
  input  logic [DB_W-1:0]  db_i,
  output logic [3:0]       out_o
);
  localparam logic [1:0] M_SINGLE = 2'b00;
  localparam logic [1:0] M_HALF   = 2'b01;
  localparam logic [1:0] M_FWD    = 2'b10;
  localparam logic [1:0] M_REV    = 2'b11;

  logic [TMR_W-1:0] tmr, per_w;
  logic [SUB_W-1:0] sub;
  logic [TB_W-1:0]  duty_w;
  logic [1:0]       mode_w, pol_w;
  logic [DB_W-1:0]  db_w, dcnt;
  logic             pwm_q, pwm_d1, run_q;
  logic [3:0]       act;

  wire [TB_W-1:0] tb_nx  = {tmr, sub} + 1'b1;
  wire            at_end = (tmr == per_w) && (&sub);
  wire            hit    = !at_end && (tb_nx == duty_w);
  wire            edge_s = pwm_q ^ pwm_d1;
  wire            blank  = (edge_s && db_w != '0) || (dcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr    <= '0;
      sub    <= '0;
      per_w  <= '0;
      duty_w <= '0;
      mode_w <= M_SINGLE;
      pol_w  <= '0;
      db_w   <= '0;
      dcnt   <= '0;
      pwm_q  <= 1'b0;
      pwm_d1 <= 1'b0;
      run_q  <= 1'b0;
    end else if (!en_i) begin
      tmr    <= period_i;
      sub    <= '1;
      per_w  <= period_i;
      duty_w <= duty_i;
      mode_w <= mode_i;
      pol_w  <= pol_i;
      db_w   <= db_i;
      dcnt   <= '0;
      pwm_q  <= 1'b0;
      pwm_d1 <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      pwm_d1 <= pwm_q;
      if (edge_s)
        dcnt <= (db_w == '0) ? '0 : db_w - 1'b1;
      else if (dcnt != '0)
        dcnt <= dcnt - 1'b1;
      if (at_end) begin
        tmr    <= '0;
        sub    <= '0;
        per_w  <= period_i;
        duty_w <= duty_i;
        mode_w <= mode_i;
        pol_w  <= pol_i;
        db_w   <= db_i;
        pwm_q  <= |duty_i;
      end else begin
        {tmr, sub} <= tb_nx;
        if (hit) begin
          pwm_q <= 1'b0;
          db_w  <= db_i;
        end
      end
    end
  end

  always_comb begin
    act = 4'b0000;
    if (run_q) begin
      case (mode_w)
        M_SINGLE: act = {3'b000, pwm_q};
        M_HALF:   act = {2'b00, !pwm_q && !blank, pwm_q && !blank};
        M_FWD:    act = {pwm_q, 2'b00, 1'b1};
        default:  act = {1'b0, 1'b1, pwm_q, 1'b0};
      endcase
    end
  end

  assign out_o = act ^ {pol_w[1], pol_w[0], pol_w[1], pol_w[0]};
endmodule

module bridge_pwm_chk #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  parameter int DB_W  = 6,
  localparam int TB_W = TMR_W + SUB_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [1:0]       pol_i,
  input logic [3:0]       out_o,
  input logic [3:0]       act,
  input logic             run_q,
  input logic             pwm_q,
  input logic [1:0]       mode_w,
  input logic [DB_W-1:0]  db_w,
  input logic [TB_W-1:0]  duty_w,
  input logic [TMR_W-1:0] tmr,
  input logic [TMR_W-1:0] per_w,
  input logic [SUB_W-1:0] sub
);
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> out_o == {$past(pol_i[1]), $past(pol_i[0]), $past(pol_i[1]), $past(pol_i[0])}); // R1
  AST_TB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> tmr <= per_w); // R2
  AST_HALF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_w == 2'b01 |-> !(act[0] && act[1])); // R6
  AST_DB_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_w == 2'b01 && db_w != '0 && $rose(pwm_q)) |-> !act[0]); // R6
  AST_FWD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_w == 2'b10) |-> (act[0] && !act[1] && !act[2])); // R7
  AST_REV_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_w == 2'b11) |-> (act[2] && !act[0] && !act[3])); // R8
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && !((tmr == per_w) && (&sub))) |=> ($stable(duty_w) && $stable(mode_w))); // R10
endmodule

bind bridge_pwm bridge_pwm_chk #(.TMR_W(TMR_W), .SUB_W(SUB_W), .DB_W(DB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .pol_i(pol_i), .out_o(out_o), .act(act),
  .run_q(run_q), .pwm_q(pwm_q), .mode_w(mode_w), .db_w(db_w), .duty_w(duty_w),
  .tmr(tmr), .per_w(per_w), .sub(sub)
);

// File: tb/bridge_pwm_tb.sv
module bridge_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] period_i = '0;
  logic [9:0] duty_i = '0;
  logic [1:0] mode_i = '0;
  logic [1:0] pol_i = '0;
  logic [5:0] db_i = '0;
  logic [3:0] out_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .period_i(period_i), .duty_i(duty_i),
    .mode_i(mode_i), .pol_i(pol_i), .db_i(db_i), .out_o(out_o)
  );

  task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] ideal(input logic [1:0] md, input logic [1:0] pl, input int m,
                                       input int du, input int p, input int dr, input int df);
    logic raw, ah, bh;
    logic [3:0] a;
    raw = m < du;
    ah  = (m >= dr) && (m < du);
    bh  = (du < p) && (m >= du + df);
    case (md)
      2'b00:   a = {3'b000, raw};
      2'b01:   a = {2'b00, bh, ah};
      2'b10:   a = {raw, 2'b00, 1'b1};
      default: a = {1'b0, 1'b1, raw, 1'b0};
    endcase
    return a ^ {pl[1], pl[0], pl[1], pl[0]};
  endfunction

  task automatic start(input logic [1:0] md, input logic [1:0] pl, input int per,
                       input int du, input int db);
    @(negedge clk);
    en_i = 1'b0;
    mode_i = md; pol_i = pl; period_i = 8'(per); duty_i = 10'(du); db_i = 6'(db);
    @(negedge clk);
    en_i = 1'b1;
  endtask

  task automatic run(input string tag, input int n, input logic [1:0] md, input logic [1:0] pl,
                     input int per, input int du, input int db);
    int p = 4 * (per + 1);
    start(md, pl, per, du, db);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(out_o, ideal(md, pl, k % p, du, p, db, db), tag);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_o, 4'b0000, "R1 reset idle");
    pol_i = 2'b11;
    @(negedge clk);
    chk(out_o, 4'b1111, "R1 R9 disabled active-low idle");
    pol_i = 2'b01;
    @(negedge clk);
    chk(out_o, 4'b0101, "R1 R9 disabled mixed idle");
  endtask

  task automatic t_single;
    run("R3 R5 single duty 6", 32, 2'b00, 2'b00, 3, 6, 0);
    run("R2 short period", 24, 2'b00, 2'b00, 1, 3, 0);
  endtask

  task automatic t_edges;
    run("R3 duty zero", 32, 2'b00, 2'b00, 3, 0, 0);
    run("R4 duty equals period", 32, 2'b00, 2'b00, 3, 16, 0);
    run("R4 duty max", 32, 2'b00, 2'b00, 3, 1023, 0);
  endtask

  task automatic t_half;
    run("R6 half db 2", 48, 2'b01, 2'b00, 3, 8, 2);
    run("R6 half db 0", 32, 2'b01, 2'b00, 3, 5, 0);
  endtask

  task automatic t_full;
    run("R7 forward", 32, 2'b10, 2'b00, 3, 5, 0);
    run("R8 reverse", 32, 2'b11, 2'b00, 3, 5, 0);
  endtask

  task automatic t_pol;
    run("R9 forward A/C low", 32, 2'b10, 2'b01, 3, 7, 0);
    run("R9 half B/D low", 32, 2'b01, 2'b10, 3, 8, 1);
    run("R9 single both low", 32, 2'b00, 2'b11, 3, 6, 0);
  endtask

  task automatic t_buffer;
    start(2'b00, 2'b00, 3, 4, 0);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (k < 16) chk(out_o, ideal(2'b00, 2'b00, k, 4, 16, 0, 0), "R10 old settings held");
      else        chk(out_o, ideal(2'b10, 2'b01, k - 16, 12, 16, 0, 0), "R10 new settings at boundary");
      if (k == 2) begin
        duty_i = 10'd12; mode_i = 2'b10; pol_i = 2'b01;
      end
    end
  endtask

  task automatic t_dbload;
    start(2'b01, 2'b00, 3, 8, 1);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (k < 16) chk(out_o, ideal(2'b01, 2'b00, k, 8, 16, 1, 3), "R11 dead band taken at duty match");
      else        chk(out_o, ideal(2'b01, 2'b00, k - 16, 8, 16, 3, 3), "R11 dead band on next rise");
      if (k == 3) db_i = 6'd3;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_edges();
    t_half();
    t_full();
    t_pol();
    t_buffer();
    t_dbload();
    @(negedge clk);
    en_i = 1'b0;
    pol_i = 2'b10;
    @(negedge clk);
    chk(out_o, 4'b1010, "R1 idle after disable");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule